// File: doc/BRIEF.md
# Length-Decoded Serial Control Port

This block is a four-wire serial control port that loads one of three control registers: an 8-bit configuration register, a 16-bit feedback-divide register and a 15-bit reference-divide register. A transfer carries no address or steering bits. The target register is chosen only by the number of serial clock rising edges seen while the active-low enable is held. Because of this, a two-byte transfer is enough to retune the feedback divider, and both bit-oriented and byte-oriented hosts can drive the port.

All four serial pins are sampled by the system clock through synchronizer stages. Data is shifted MSB first into a 24-bit shift register. When enable is released, the register named by the edge count takes the low bits of the shift register. A write to the feedback-divide register also fires a one-cycle jam-load strobe, which the divider logic uses to restart its counters together. The top bit of the shift register is driven on the serial output, so several ports can be chained. The output carries an enable flag that is low whenever the port is not selected, and this flag marks the serial output as high-impedance.

Top module: `serial_ctl_port`

## Requirements
- R1: After reset, `cfg_o`, `ndiv_o` and `rdiv_o` are all zero and `jam_o` and `sdo_oe` are low.
- R2: A frame of exactly 8 rising `sclk` edges loads `cfg_o` with the last 8 bits received. The first bit received becomes the MSB.
- R3: A frame of exactly 16 edges loads `ndiv_o` with the last 16 bits received, first bit as MSB.
- R4: A frame of exactly 24 edges loads `rdiv_o` with bits 14..0 of the 24 bits received. Bit 0 is the last bit received.
- R5: A frame with any other edge count changes none of the three registers. This includes zero edges, counts between the valid lengths and counts above 24.
- R6: `jam_o` is high for exactly one system clock after each 16-edge frame and is never high otherwise. It rises in the cycle in which `ndiv_o` takes its new value.
- R7: `sdo` always equals bit 23 of the shift register, which is the bit received 24 edges earlier. Bits therefore pass through to a chained port.
- R8: `sdo_oe` is high while `sen_n` is low and low while `sen_n` is high, after the synchronizer delay.
- R9: `sclk` edges while `sen_n` is high neither shift data nor count toward the next frame.
- R10: The edge count saturates and does not wrap. A 40-edge frame is rejected even though 40 is congruent to 8 modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, data taken on rising edges |
| sen_n | input | 1 | Active-low port enable, frames a transfer |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out, top bit of the shift register |
| sdo_oe | output | 1 | Output enable for `sdo`, low means high-impedance |
| cfg_o | output | 8 | Configuration register |
| ndiv_o | output | 16 | Feedback-divide register |
| rdiv_o | output | 15 | Reference-divide register |
| jam_o | output | 1 | One-cycle jam-load strobe after a feedback-divide write |

## Verification
The assertions assume that every `sclk` level and every `sen_n` level lasts for several system clocks. They also assume that `sdi` is stable around each rising `sclk` edge, so that each serial edge gives exactly one synchronized edge event. The stimulus holds each `sclk` phase for four system clocks and changes `sdi` only while `sclk` is low. It waits four cycles between moving `sen_n` and the nearest `sclk` edge. Under these conditions the count at enable release is exact. The sweep covers every frame length from 0 to 26 and then 40, and each expected register value comes from a bit-level model of the received stream.

// File: rtl/serial_ctl_port.sv
module serial_ctl_port #(
  parameter int CFG_W       = 8,
  parameter int NDIV_W      = 16,
  parameter int RDIV_W      = 15,
  parameter int LONG_LEN    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sen_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [NDIV_W-1:0] ndiv_o,
  output logic [RDIV_W-1:0] rdiv_o,
  output logic              jam_o
);

  localparam int SR_W  = LONG_LEN;
  localparam int CNT_W = $clog2(LONG_LEN + 8);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LEN_CFG   = CNT_W'(CFG_W);
  localparam logic [CNT_W-1:0] LEN_NDIV  = CNT_W'(NDIV_W);
  localparam logic [CNT_W-1:0] LEN_RDIV  = CNT_W'(LONG_LEN);

  logic [SYNC_STAGES:0] sclk_q, sen_q, sdi_q;
  logic [SR_W-1:0]      sr;
  logic [CNT_W-1:0]     cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      sen_q  <= '1;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-1:0], sclk};
      sen_q  <= {sen_q[SYNC_STAGES-1:0], sen_n};
      sdi_q  <= {sdi_q[SYNC_STAGES-1:0], sdi};
    end
  end

  wire enabled   = ~sen_q[SYNC_STAGES-1];
  wire sclk_rise = sclk_q[SYNC_STAGES-1] & ~sclk_q[SYNC_STAGES];
  wire frame_end = sen_q[SYNC_STAGES-1] & ~sen_q[SYNC_STAGES];
  wire data_bit  = sdi_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (enabled) begin
      if (sclk_rise) begin
        sr <= {sr[SR_W-2:0], data_bit};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o  <= '0;
      ndiv_o <= '0;
      rdiv_o <= '0;
      jam_o  <= 1'b0;
    end else begin
      jam_o <= 1'b0;
      if (frame_end) begin
        if (cnt == LEN_CFG)  cfg_o  <= sr[CFG_W-1:0];
        if (cnt == LEN_NDIV) begin
          ndiv_o <= sr[NDIV_W-1:0];
          jam_o  <= 1'b1;
        end
        if (cnt == LEN_RDIV) rdiv_o <= sr[RDIV_W-1:0];
      end
    end
  end

  assign sdo    = sr[SR_W-1];
  assign sdo_oe = enabled;

  // R6
  jam_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jam_o |=> !jam_o);

  // R6
  jam_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jam_o |-> $past(cnt) == LEN_NDIV);

  // R3
  ndiv_only_with_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ndiv_o != $past(ndiv_o)) |-> jam_o);

  // R2
  cfg_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o != $past(cfg_o)) |-> $past(cnt) == LEN_CFG);

  // R4
  rdiv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdiv_o != $past(rdiv_o)) |-> $past(cnt) == LEN_RDIV);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |=> $stable(sdo));

  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && sdo_oe) |=> (cnt == CNT_MAX || !sdo_oe));

endmodule

// File: tb/serial_ctl_port_tb.sv
module serial_ctl_port_tb;
  logic clk = 0, rst_n = 0, sclk = 0, sen_n = 1, sdi = 0;
  logic sdo, sdo_oe, jam_o;
  logic [7:0]  cfg_o;
  logic [15:0] ndiv_o;
  logic [14:0] rdiv_o;

  int checks = 0, errors = 0, jam_cnt = 0, jam_double = 0;
  logic [23:0] msr = '0;
  logic [7:0]  e_cfg = '0;
  logic [15:0] e_ndiv = '0;
  logic [14:0] e_rdiv = '0;
  logic jam_prev = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_ctl_port u_dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sen_n(sen_n),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .cfg_o(cfg_o), .ndiv_o(ndiv_o),
    .rdiv_o(rdiv_o), .jam_o(jam_o));

  always @(posedge clk) begin
    if (jam_o) jam_cnt <= jam_cnt + 1;
    if (jam_o && jam_prev) jam_double <= jam_double + 1;
    jam_prev <= jam_o;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stray_edges(input int n);
    for (int i = 0; i < n; i++) begin
      sdi = ~sdi; wait_clk(4); sclk = 1; wait_clk(4); sclk = 0;
    end
    wait_clk(4);
  endtask

  task automatic frame(input int len, input logic [31:0] v);
    int jam_before;
    jam_before = jam_cnt;
    sen_n = 0;
    wait_clk(4);
    chk(sdo_oe == 1'b1, "R8", sdo_oe, 1);
    for (int k = 0; k < len; k++) begin
      sdi = v[(k * 7 + 3) % 32];
      msr = {msr[22:0], sdi};
      wait_clk(4); sclk = 1; wait_clk(4); sclk = 0;
    end
    wait_clk(4);
    sen_n = 1;
    if (len == 8)  e_cfg  = msr[7:0];
    if (len == 16) e_ndiv = msr[15:0];
    if (len == 24) e_rdiv = msr[14:0];
    wait_clk(10);
    chk(sdo_oe == 1'b0, "R8", sdo_oe, 0);
    chk(cfg_o == e_cfg, (len == 8) ? "R2" : "R5", cfg_o, e_cfg);
    chk(ndiv_o == e_ndiv, (len == 16) ? "R3" : "R5", ndiv_o, e_ndiv);
    chk(rdiv_o == e_rdiv, (len == 24) ? "R4" : (len == 40 ? "R10" : "R5"), rdiv_o, e_rdiv);
    chk(jam_cnt - jam_before == ((len == 16) ? 1 : 0), "R6", jam_cnt - jam_before, (len == 16) ? 1 : 0);
    chk(sdo == msr[23], "R7", sdo, msr[23]);
  endtask

  initial begin
    wait_clk(3);
    chk(cfg_o == 0 && ndiv_o == 0 && rdiv_o == 0, "R1", {cfg_o, ndiv_o, rdiv_o}, 0);
    chk(jam_o == 0 && sdo_oe == 0, "R1", {jam_o, sdo_oe}, 0);
    rst_n = 1;
    wait_clk(3);
    for (int len = 0; len <= 26; len++) begin
      if (len % 3 == 0) begin
        stray_edges(3);
        chk(sdo == msr[23], "R9", sdo, msr[23]);
      end
      frame(len, 32'h9E3779B9 * (len + 1));
    end
    frame(8, 32'hA5C3_0F71);
    frame(16, 32'h1234_ABCD);
    stray_edges(5);
    frame(24, 32'hFEDC_4321);
    frame(40, 32'h0BAD_F00D);
    frame(16, 32'h7777_1111);
    chk(jam_double == 0, "R6", jam_double, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        wait_clk(150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule